// File: doc/BRIEF.md
# NMI and IRL Request Front End

This block is the front end of an interrupt path. It watches a non-maskable interrupt input and four active-low interrupt request pins, and turns them into two outputs: an NMI request and a 4-bit request level. Every pin passes through a two-flop synchroniser before any edge or level is evaluated. A 16-bit control register sets the NMI edge, the NMI blocking behaviour, the NMI mask and how the request pins are read. Bit 15 of the register reads back the synchronised NMI input level and cannot be written.

The NMI detector samples the synchronised level and catches either a falling edge or a rising edge. A detected edge sets a sticky pending flag. The flag drives the `nmi_req` output unless one of two things holds it back. The first is the mask bit. The second is the CPU block input, when the register selects holding mode. The request stays high until `nmi_ack` is asserted in a cycle where `nmi_req` is high. The request pins give a level in one of two ways. In encoded mode the four pins are read as one inverted binary level. In independent mode each pin is a separate request with a fixed level, and the highest active level wins. Comparing that level against a CPU mask is done outside this block.

Top module: `intreq_front`

## Requirements
- R1: After reset, the writable register fields are 0, `nmi_req` is 0, and with all request pins high `irl_level` is 0. With the NMI pin held high, `cfg_rdata` reads 16'h8000.
- R2: Only bits 14, 9, 8 and 7 of the control register can be written. All other bits read 0, except bit 15, which reads the synchronised NMI pin level two clock edges after the pin changes. Writes to bit 15 are ignored.
- R3: With bit 8 = 0, a falling edge on the NMI pin sets the pending flag and a rising edge does not.
- R4: With bit 8 = 1, a rising edge on the NMI pin sets the pending flag and a falling edge does not.
- R5: With bit 9 = 0 and `cpu_block` = 1, `nmi_req` stays 0 while the pending flag is kept. `nmi_req` goes to 1 in the same cycle that `cpu_block` falls.
- R6: With bit 9 = 1, a pending NMI drives `nmi_req` even while `cpu_block` = 1.
- R7: With bit 14 = 1, `nmi_req` stays 0 while the pending flag is kept. Clearing bit 14 raises `nmi_req`.
- R8: Once set, the pending flag stays set until `nmi_ack` is high in a cycle where `nmi_req` is high. An `nmi_ack` while `nmi_req` is low has no effect.
- R9: With bit 7 = 0, `irl_level` is the bitwise inverse of the synchronised pin value, so pins 4'hF give level 0.
- R10: With bit 7 = 1, a low pin i (i = 0 to 3) requests level 13 - 3*i, which gives 13, 10, 7 and 4. `irl_level` is the highest requested level, or 0 when all pins are high.
- R11: A change on the request pins shows on `irl_level` after two rising clock edges. An NMI edge shows on `nmi_req` after three rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read value, with the live NMI level in bit 15 |
| nmi_in | input | 1 | Asynchronous NMI pin |
| irl_n | input | 4 | Asynchronous active-low request pins |
| cpu_block | input | 1 | CPU block signal |
| nmi_ack | input | 1 | Accepts the current NMI request |
| nmi_req | output | 1 | NMI request, held until acknowledged |
| irl_level | output | 4 | Decoded request level, 0 = none |

## Verification
The assertions check on every cycle that a pending NMI is kept until it is acknowledged, and that the pending flag never rises without a detected edge in the cycle before. They also check that the mask and the holding mode keep `nmi_req` low, and that independent mode only produces one of the five allowed levels. Other behaviours can only be shown by the bench's scenarios. These are the pipeline latencies, the choice of edge polarity, the exact level produced for each of the sixteen pin patterns in both modes, the register read-back mask, and the release of a held request when blocking or masking ends.

// File: rtl/intreq_pkg.sv
package intreq_pkg;
  localparam int REG_W    = 16;
  localparam int N_IRL    = 4;
  localparam int LVL_W    = 4;
  localparam int LVL_TOP  = 13;
  localparam int LVL_STEP = 3;

  // control register bit positions
  localparam int B_NMI_LVL = 15;
  localparam int B_MASK    = 14;
  localparam int B_NONBLK  = 9;
  localparam int B_RISE    = 8;
  localparam int B_INDEP   = 7;

  typedef struct packed {
    logic mask;
    logic nonblk;
    logic rise;
    logic indep;
  } cfg_t;

  // fixed level of independent request pin i
  function automatic logic [LVL_W-1:0] pin_level(input int i);
    return LVL_W'(LVL_TOP - LVL_STEP * i);
  endfunction

  // encoded mode: active-low pins form one binary level
  function automatic logic [LVL_W-1:0] lvl_encoded(input logic [N_IRL-1:0] pins_n);
    return LVL_W'(~pins_n);
  endfunction

  // independent mode: largest level among the low pins
  function automatic logic [LVL_W-1:0] lvl_indep(input logic [N_IRL-1:0] pins_n);
    logic [LVL_W-1:0] best;
    best = '0;
    for (int i = 0; i < N_IRL; i++) begin
      if (!pins_n[i] && pin_level(i) > best) best = pin_level(i);
    end
    return best;
  endfunction

  function automatic logic [REG_W-1:0] pack_read(input logic nmi_lvl, input cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_NMI_LVL] = nmi_lvl;
    r[B_MASK]    = c.mask;
    r[B_NONBLK]  = c.nonblk;
    r[B_RISE]    = c.rise;
    r[B_INDEP]   = c.indep;
    return r;
  endfunction
endpackage

// File: rtl/intreq_sync.sv
module intreq_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/intreq_nmi_det.sv
module intreq_nmi_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  input  logic nonblk,
  input  logic mask,
  input  logic block,
  input  logic ack,
  output logic edge_evt,
  output logic pend,
  output logic req
);
  logic lvl_d;
  logic pend_q;
  logic accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b1;
    else        lvl_d <= lvl;
  end

  assign edge_evt = rise_sel ? (lvl & ~lvl_d) : (~lvl & lvl_d);
  assign req      = pend_q & ~mask & (~block | nonblk);
  assign accept   = ack & req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (edge_evt) pend_q <= 1'b1;
    else if (accept)   pend_q <= 1'b0;
  end

  assign pend = pend_q;
endmodule

// File: rtl/intreq_irl_dec.sv
module intreq_irl_dec
  import intreq_pkg::*;
(
  input  logic [N_IRL-1:0] pins_n,
  input  logic             indep,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    if (indep) level = lvl_indep(pins_n);
    else       level = lvl_encoded(pins_n);
  end
endmodule

// File: rtl/intreq_front.sv
module intreq_front
  import intreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        nmi_in,
  input  logic [3:0]  irl_n,
  input  logic        cpu_block,
  input  logic        nmi_ack,
  output logic        nmi_req,
  output logic [3:0]  irl_level
);
  cfg_t             cfg_q;
  logic             nmi_sync;
  logic [N_IRL-1:0] irl_sync;
  logic             edge_evt;
  logic             pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.mask   <= cfg_wdata[B_MASK];
      cfg_q.nonblk <= cfg_wdata[B_NONBLK];
      cfg_q.rise   <= cfg_wdata[B_RISE];
      cfg_q.indep  <= cfg_wdata[B_INDEP];
    end
  end

  intreq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .d(nmi_in), .q(nmi_sync)
  );

  intreq_sync #(.W(N_IRL), .STAGES(SYNC_STAGES), .RST_VAL({N_IRL{1'b1}})) u_irl_sync (
    .clk(clk), .rst_n(rst_n), .d(irl_n), .q(irl_sync)
  );

  intreq_nmi_det u_nmi_det (
    .clk(clk), .rst_n(rst_n), .lvl(nmi_sync), .rise_sel(cfg_q.rise),
    .nonblk(cfg_q.nonblk), .mask(cfg_q.mask), .block(cpu_block),
    .ack(nmi_ack), .edge_evt(edge_evt), .pend(pend_q), .req(nmi_req)
  );

  intreq_irl_dec u_irl_dec (
    .pins_n(irl_sync), .indep(cfg_q.indep), .level(irl_level)
  );

  assign cfg_rdata = pack_read(nmi_sync, cfg_q);
endmodule

// File: rtl/intreq_front_chk.sv
module intreq_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       edge_evt,
  input logic       pend_q,
  input logic       nmi_req,
  input logic       nmi_ack,
  input logic       cpu_block,
  input logic       cfg_mask,
  input logic       cfg_nonblk,
  input logic       cfg_indep,
  input logic [3:0] irl_level
);
  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(nmi_ack && nmi_req)) |=> pend_q);

  // R8
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(edge_evt));

  // R3
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> pend_q);

  // R5
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_block && !cfg_nonblk) |-> !nmi_req);

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask |-> !nmi_req);

  // R10
  indep_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_indep |-> (irl_level inside {4'd0, 4'd4, 4'd7, 4'd10, 4'd13}));
endmodule

bind intreq_front intreq_front_chk u_front_chk (
  .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .pend_q(pend_q),
  .nmi_req(nmi_req), .nmi_ack(nmi_ack), .cpu_block(cpu_block),
  .cfg_mask(cfg_q.mask), .cfg_nonblk(cfg_q.nonblk), .cfg_indep(cfg_q.indep),
  .irl_level(irl_level)
);

// File: tb/intreq_front_bench.sv
module intreq_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        nmi_in = 1'b1;
  logic [3:0]  irl_n = 4'hF;
  logic        cpu_block = 1'b0;
  logic        nmi_ack = 1'b0;
  logic        nmi_req;
  logic [3:0]  irl_level;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  intreq_front u_intreq_front (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .nmi_in(nmi_in), .irl_n(irl_n),
    .cpu_block(cpu_block), .nmi_ack(nmi_ack), .nmi_req(nmi_req),
    .irl_level(irl_level)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick(1);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic ack_once();
    nmi_ack = 1'b1;
    tick(1);
    nmi_ack = 1'b0;
  endtask

  // bench-side level model: fixed priority order of the pins
  function automatic logic [3:0] exp_indep(input logic [3:0] v);
    if (!v[0]) return 4'd13;
    if (!v[1]) return 4'd10;
    if (!v[2]) return 4'd7;
    if (!v[3]) return 4'd4;
    return 4'd0;
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 16'h8000);
    chk("R1 nmi_req", {15'd0, nmi_req}, 16'd0);
    chk("R1 irl_level", {12'd0, irl_level}, 16'd0);

    // R2 writable mask
    wr(16'hFFFF);
    chk("R2 write all ones", cfg_rdata, 16'hC380);
    wr(16'h0000);
    chk("R2 write zero", cfg_rdata, 16'h8000);

    // R3 falling edge, R11 latency
    nmi_in = 1'b0;
    tick(1);
    chk("R2 level not yet", {15'd0, cfg_rdata[15]}, 16'd1);
    tick(1);
    chk("R2 level after two edges", {15'd0, cfg_rdata[15]}, 16'd0);
    chk("R11 nmi not yet", {15'd0, nmi_req}, 16'd0);
    tick(1);
    chk("R3 falling detected", {15'd0, nmi_req}, 16'd1);
    tick(3);
    chk("R8 held until ack", {15'd0, nmi_req}, 16'd1);
    ack_once();
    chk("R8 ack clears", {15'd0, nmi_req}, 16'd0);
    nmi_in = 1'b1;
    tick(5);
    chk("R3 rising ignored", {15'd0, nmi_req}, 16'd0);

    // R4 rising edge mode
    wr(16'h0100);
    nmi_in = 1'b0;
    tick(5);
    chk("R4 falling ignored", {15'd0, nmi_req}, 16'd0);
    nmi_in = 1'b1;
    tick(3);
    chk("R4 rising detected", {15'd0, nmi_req}, 16'd1);
    ack_once();
    chk("R4 ack clears", {15'd0, nmi_req}, 16'd0);

    // R5 hold while blocked
    cpu_block = 1'b1;
    nmi_in = 1'b0; tick(4);
    nmi_in = 1'b1; tick(5);
    chk("R5 held while blocked", {15'd0, nmi_req}, 16'd0);
    cpu_block = 1'b0;
    #1;
    chk("R5 released on unblock", {15'd0, nmi_req}, 16'd1);
    tick(1);
    ack_once();
    chk("R5 ack clears", {15'd0, nmi_req}, 16'd0);

    // R6 delivered while blocked
    wr(16'h0300);
    cpu_block = 1'b1;
    nmi_in = 1'b0; tick(4);
    nmi_in = 1'b1; tick(3);
    chk("R6 delivered while blocked", {15'd0, nmi_req}, 16'd1);
    ack_once();
    chk("R6 ack clears", {15'd0, nmi_req}, 16'd0);
    cpu_block = 1'b0;

    // R7 mask, R8 ack ignored while req low
    wr(16'h4100);
    nmi_in = 1'b0; tick(4);
    nmi_in = 1'b1; tick(4);
    chk("R7 masked", {15'd0, nmi_req}, 16'd0);
    ack_once();
    wr(16'h0100);
    chk("R7 unmask releases", {15'd0, nmi_req}, 16'd1);
    chk("R8 ack while low ignored", {15'd0, nmi_req}, 16'd1);
    ack_once();
    chk("R8 final clear", {15'd0, nmi_req}, 16'd0);

    // R9 encoded mode, R11 latency
    wr(16'h0000);
    irl_n = 4'hE;
    tick(1);
    chk("R11 irl not yet", {12'd0, irl_level}, 16'd0);
    tick(1);
    chk("R11 irl after two edges", {12'd0, irl_level}, 16'd1);
    for (int v = 0; v < 16; v++) begin
      irl_n = 4'(v);
      tick(2);
      chk($sformatf("R9 encoded pins=%0h", v), {12'd0, irl_level}, {12'd0, ~4'(v)});
    end

    // R10 independent mode
    wr(16'h0080);
    for (int v = 0; v < 16; v++) begin
      irl_n = 4'(v);
      tick(2);
      chk($sformatf("R10 indep pins=%0h", v), {12'd0, irl_level}, {12'd0, exp_indep(4'(v))});
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule